// File: doc/BRIEF.md
# Trap Entry and Shadow State Unit

This block keeps the architectural control state of a small multithreaded core: the program counter, the interrupt-enable flag, the supervisor-mode flag and the count of active threads. It also keeps the general and predicate registers of thread 0. Each retiring instruction is presented on `step` with its length and any register, predicate or control write it makes. The unit advances the PC by that length, and the PC wraps at the word width.

When a trap request arrives and interrupts are enabled, the unit takes the trap on one clock edge. On that edge it copies the thread count, the flags, the saved PC and every thread-0 general and predicate register into shadow storage. It then collapses execution to one thread, clears interrupt enable, enters supervisor mode, writes the cause code into register 0 and jumps to a programmable entry address. A page-fault trap then spends one extra cycle writing the faulting address into register 1. A thread count of zero halts the unit until reset.

The control FSM has three named states. `ST_RUN` is normal operation. `ST_FLTWB` is the single write-back cycle for the fault address. `ST_HALT` holds all state frozen. The transitions are:
- RUN→FLTWB on an accepted trap with cause 1 or 2.
- RUN→HALT when a retiring control write sets the thread count to 0 with no trap on that edge.
- FLTWB→RUN always.
- HALT→HALT always.
- RUN→RUN otherwise.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset the PC is 0, `ie` is 0, `sup` is 1 and `act_thr` is 1. Register 0 reads `(NTHDS << (W/2)) | CORE_ID`, which is 0x0403 with the defaults. All other general and predicate registers read 0.
- R2: In `ST_RUN`, a `step` without an accepted trap sets the PC to `(pc + inst_len) mod 2^W` on that edge. The same edge applies the cycle's general-register write (`gpr_we`), predicate write (`prd_we`), control write (`ctl_we` loads `ie`, `sup` and `act_thr`) and entry write (`ent_we`).
- R3: A trap request while `ie` is 0 is not taken. `trap_taken` stays 0, the step proceeds as in R2, and register 0 keeps the value written by the step.
- R4: On an accepted trap, the shadow copies receive the pre-edge values of `act_thr`, `ie`, `sup`, every general register and every predicate bit.
- R5: After an accepted trap, `act_thr` is 1, `ie` is 0, `sup` is 1, the PC equals the entry address held before the edge, and register 0 holds the cause code. `trap_taken` is 1 for exactly the cycle after the edge.
- R6: The shadow PC is the pre-trap PC when `trap_rewind` is 1. When `trap_rewind` is 0, it is the PC as R2 would advance it (unchanged if `step` is 0). Cause codes are 1 for a missing mapping, 2 for another page fault, 4 for a divergent branch and 5 for a domain exception.
- R7: For causes 1 and 2, register 1 holds `fault_addr` one cycle after the trap edge. During that write-back cycle, `step` and everything it carries are ignored. Other causes leave register 1 alone, and the next cycle runs normally.
- R8: A retiring write to register 0 on the same edge as an accepted trap is lost; the cause code is stored instead.
- R9: When `act_thr` is 0, neither `step` nor `trap_req` changes the PC, the flags, the thread count or any register, and `trap_taken` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | An instruction retires this cycle |
| inst_len | input | LW | Length of the retiring instruction |
| gpr_we | input | 1 | General-register write by the retiring instruction |
| gpr_idx | input | IW | General-register write index |
| gpr_wdata | input | W | General-register write data |
| prd_we | input | 1 | Predicate write by the retiring instruction |
| prd_idx | input | PIW | Predicate write index |
| prd_wdata | input | 1 | Predicate write value |
| ctl_we | input | 1 | Control-flag write by the retiring instruction |
| ctl_ie | input | 1 | New interrupt-enable value |
| ctl_sup | input | 1 | New supervisor-mode value |
| ctl_thr | input | TW | New active-thread count |
| ent_we | input | 1 | Entry-address write by the retiring instruction |
| ent_addr | input | W | New trap entry address |
| trap_req | input | 1 | Trap request |
| trap_cause | input | 3 | Cause code (1, 2, 4, 5) |
| trap_rewind | input | 1 | Save the un-advanced PC |
| fault_addr | input | W | Faulting address for page faults |
| rd_idx | input | IW | General-register read index |
| rd_data | output | W | General-register read data |
| prd_rd_idx | input | PIW | Predicate read index |
| prd_rd_data | output | 1 | Predicate read value |
| sh_idx | input | IW | Shadow register read index |
| sh_data | output | W | Shadow register read data |
| sh_prd | output | NPREGS | Shadow predicate bits |
| sh_pc | output | W | Shadow PC |
| sh_ie | output | 1 | Shadow interrupt enable |
| sh_sup | output | 1 | Shadow supervisor mode |
| sh_thr | output | TW | Shadow active-thread count |
| pc | output | W | Program counter |
| ie | output | 1 | Interrupt enable |
| sup | output | 1 | Supervisor mode |
| act_thr | output | TW | Active-thread count |
| trap_taken | output | 1 | One-cycle pulse after an accepted trap |

## Verification
Inputs are driven just after a falling edge. The state and shadow results of a step or trap are therefore due on the following rising edge and are read at the falling edge after it, one cycle later. `trap_taken` is registered, so it is read in that same cycle and again one cycle later, where it must have dropped. The register-1 fault write lands one cycle after the trap. The bench therefore reads it only after the stalled write-back cycle, which is also where it checks that the step offered during that cycle left the PC and register 2 untouched. The sweep covers every cause code with and without rewind, and computes each expected PC arithmetically from the lengths it applied.

// File: rtl/trap_pkg.sv
package trap_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_FLTWB = 2'd1,
        ST_HALT  = 2'd2
    } ctl_state_e;

    localparam logic [2:0] CAUSE_NOMAP   = 3'd1;
    localparam logic [2:0] CAUSE_PROT    = 3'd2;
    localparam logic [2:0] CAUSE_DIVERGE = 3'd4;
    localparam logic [2:0] CAUSE_DOMAIN  = 3'd5;
endpackage

// File: rtl/trap_regfile.sv
module trap_regfile #(
    parameter int W      = 16,
    parameter int NREGS  = 8,
    parameter int NPREGS = 4,
    parameter logic [W-1:0] RST0 = '0,
    localparam int IW  = $clog2(NREGS),
    localparam int PIW = $clog2(NPREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ret_we,
    input  logic [IW-1:0]     ret_idx,
    input  logic [W-1:0]      ret_data,
    input  logic              pret_we,
    input  logic [PIW-1:0]    pret_idx,
    input  logic              pret_data,
    input  logic              snap,
    input  logic [W-1:0]      cause_w,
    input  logic              fwb_en,
    input  logic [W-1:0]      fwb_data,
    input  logic [IW-1:0]     rd_idx,
    output logic [W-1:0]      rd_data,
    input  logic [PIW-1:0]    prd_idx,
    output logic              prd_data,
    input  logic [IW-1:0]     sh_idx,
    output logic [W-1:0]      sh_data,
    output logic [NPREGS-1:0] sh_prd
);
    logic [W-1:0]      gpr_q [NREGS];
    logic [W-1:0]      sh_q  [NREGS];
    logic [NPREGS-1:0] prd_q;
    logic [NPREGS-1:0] shp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) begin
                gpr_q[i] <= (i == 0) ? RST0 : '0;
                sh_q[i]  <= '0;
            end
            prd_q <= '0;
            shp_q <= '0;
        end else begin
            for (int i = 0; i < NREGS; i++) begin
                if (snap) sh_q[i] <= gpr_q[i];
                if (i == 0 && snap)
                    gpr_q[i] <= cause_w;
                else if (i == 1 && fwb_en)
                    gpr_q[i] <= fwb_data;
                else if (ret_we && ret_idx == IW'(i))
                    gpr_q[i] <= ret_data;
            end
            if (snap) shp_q <= prd_q;
            if (pret_we) prd_q[pret_idx] <= pret_data;
        end
    end

    assign rd_data  = gpr_q[rd_idx];
    assign prd_data = prd_q[prd_idx];
    assign sh_data  = sh_q[sh_idx];
    assign sh_prd   = shp_q;

    // R5
    cause_r0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> gpr_q[0] == $past(cause_w));
    // R4
    shadow_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> (sh_q[NREGS-1] == $past(gpr_q[NREGS-1]) && shp_q == $past(prd_q)));
endmodule

// File: rtl/trap_ctl.sv
module trap_ctl
    import trap_pkg::*;
#(
    parameter int W  = 16,
    parameter int LW = 4,
    parameter int TW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic [LW-1:0] inst_len,
    input  logic          ctl_we,
    input  logic          ctl_ie,
    input  logic          ctl_sup,
    input  logic [TW-1:0] ctl_thr,
    input  logic          ent_we,
    input  logic [W-1:0]  ent_addr,
    input  logic          trap_req,
    input  logic [2:0]    trap_cause,
    input  logic          trap_rewind,
    input  logic [W-1:0]  fault_addr,
    output logic          retire_en,
    output logic          snap,
    output logic          fwb_en,
    output logic [W-1:0]  fwb_data,
    output logic [W-1:0]  pc,
    output logic          ie,
    output logic          sup,
    output logic [TW-1:0] act_thr,
    output logic [W-1:0]  sh_pc,
    output logic          sh_ie,
    output logic          sh_sup,
    output logic [TW-1:0] sh_thr,
    output logic          trap_taken
);
    ctl_state_e    state_q, state_d;
    logic [W-1:0]  pc_q, entry_q, fa_q, sh_pc_q, adv_pc;
    logic          ie_q, sup_q, sh_ie_q, sh_sup_q, taken_q;
    logic [TW-1:0] thr_q, sh_thr_q;
    logic          run, take, pf_cause;

    // Output process: decode of the current state
    always_comb begin
        run       = 1'b0;
        fwb_en    = 1'b0;
        unique case (state_q)
            ST_RUN:   run    = 1'b1;
            ST_FLTWB: fwb_en = 1'b1;
            ST_HALT:  ;
            default:  ;
        endcase
        take      = run && trap_req && ie_q;
        retire_en = run && step;
        snap      = take;
    end

    assign pf_cause = (trap_cause == CAUSE_NOMAP) || (trap_cause == CAUSE_PROT);
    assign adv_pc   = pc_q + W'(inst_len);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (take && pf_cause)
                    state_d = ST_FLTWB;
                else if (!take && retire_en && ctl_we && ctl_thr == '0)
                    state_d = ST_HALT;
            end
            ST_FLTWB: state_d = ST_RUN;
            ST_HALT:  state_d = ST_HALT;
            default:  state_d = ST_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q     <= '0;
            ie_q     <= 1'b0;
            sup_q    <= 1'b1;
            thr_q    <= TW'(1);
            entry_q  <= '0;
            fa_q     <= '0;
            sh_pc_q  <= '0;
            sh_ie_q  <= 1'b0;
            sh_sup_q <= 1'b0;
            sh_thr_q <= '0;
            taken_q  <= 1'b0;
        end else begin
            taken_q <= take;
            if (retire_en && ent_we) entry_q <= ent_addr;
            if (take) begin
                sh_pc_q  <= trap_rewind ? pc_q : (step ? adv_pc : pc_q);
                sh_ie_q  <= ie_q;
                sh_sup_q <= sup_q;
                sh_thr_q <= thr_q;
                fa_q     <= fault_addr;
                pc_q     <= entry_q;
                ie_q     <= 1'b0;
                sup_q    <= 1'b1;
                thr_q    <= TW'(1);
            end else if (retire_en) begin
                pc_q <= adv_pc;
                if (ctl_we) begin
                    ie_q  <= ctl_ie;
                    sup_q <= ctl_sup;
                    thr_q <= ctl_thr;
                end
            end
        end
    end

    assign fwb_data   = fa_q;
    assign pc         = pc_q;
    assign ie         = ie_q;
    assign sup        = sup_q;
    assign act_thr    = thr_q;
    assign sh_pc      = sh_pc_q;
    assign sh_ie      = sh_ie_q;
    assign sh_sup     = sh_sup_q;
    assign sh_thr     = sh_thr_q;
    assign trap_taken = taken_q;

    // R3
    trap_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !ie_q) |=> !trap_taken);
    // R5
    trap_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (!ie_q && sup_q && thr_q == TW'(1) && pc_q == $past(entry_q) && trap_taken));
    // R6
    rewind_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && trap_rewind) |=> sh_pc_q == $past(pc_q));
    // R7
    fwb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLTWB) |=> (state_q == ST_RUN && $stable(pc_q)));
    // R9
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT) |=> ($stable(pc_q) && $stable(ie_q) && thr_q == '0 && !trap_taken));
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit #(
    parameter int W       = 16,
    parameter int NTHDS   = 4,
    parameter int CORE_ID = 3,
    parameter int NREGS   = 8,
    parameter int NPREGS  = 4,
    parameter int LW      = 4,
    localparam int TW  = $clog2(NTHDS + 1),
    localparam int IW  = $clog2(NREGS),
    localparam int PIW = $clog2(NPREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [LW-1:0]     inst_len,
    input  logic              gpr_we,
    input  logic [IW-1:0]     gpr_idx,
    input  logic [W-1:0]      gpr_wdata,
    input  logic              prd_we,
    input  logic [PIW-1:0]    prd_idx,
    input  logic              prd_wdata,
    input  logic              ctl_we,
    input  logic              ctl_ie,
    input  logic              ctl_sup,
    input  logic [TW-1:0]     ctl_thr,
    input  logic              ent_we,
    input  logic [W-1:0]      ent_addr,
    input  logic              trap_req,
    input  logic [2:0]        trap_cause,
    input  logic              trap_rewind,
    input  logic [W-1:0]      fault_addr,
    input  logic [IW-1:0]     rd_idx,
    output logic [W-1:0]      rd_data,
    input  logic [PIW-1:0]    prd_rd_idx,
    output logic              prd_rd_data,
    input  logic [IW-1:0]     sh_idx,
    output logic [W-1:0]      sh_data,
    output logic [NPREGS-1:0] sh_prd,
    output logic [W-1:0]      sh_pc,
    output logic              sh_ie,
    output logic              sh_sup,
    output logic [TW-1:0]     sh_thr,
    output logic [W-1:0]      pc,
    output logic              ie,
    output logic              sup,
    output logic [TW-1:0]     act_thr,
    output logic              trap_taken
);
    localparam logic [W-1:0] RST0 = (W'(NTHDS) << (W / 2)) | W'(CORE_ID);

    logic         retire_en, snap, fwb_en;
    logic [W-1:0] fwb_data;

    trap_ctl #(.W(W), .LW(LW), .TW(TW)) u_ctl (
        .clk(clk), .rst_n(rst_n), .step(step), .inst_len(inst_len),
        .ctl_we(ctl_we), .ctl_ie(ctl_ie), .ctl_sup(ctl_sup), .ctl_thr(ctl_thr),
        .ent_we(ent_we), .ent_addr(ent_addr),
        .trap_req(trap_req), .trap_cause(trap_cause), .trap_rewind(trap_rewind),
        .fault_addr(fault_addr),
        .retire_en(retire_en), .snap(snap), .fwb_en(fwb_en), .fwb_data(fwb_data),
        .pc(pc), .ie(ie), .sup(sup), .act_thr(act_thr),
        .sh_pc(sh_pc), .sh_ie(sh_ie), .sh_sup(sh_sup), .sh_thr(sh_thr),
        .trap_taken(trap_taken)
    );

    trap_regfile #(.W(W), .NREGS(NREGS), .NPREGS(NPREGS), .RST0(RST0)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .ret_we(retire_en && gpr_we), .ret_idx(gpr_idx), .ret_data(gpr_wdata),
        .pret_we(retire_en && prd_we), .pret_idx(prd_idx), .pret_data(prd_wdata),
        .snap(snap), .cause_w(W'(trap_cause)),
        .fwb_en(fwb_en), .fwb_data(fwb_data),
        .rd_idx(rd_idx), .rd_data(rd_data),
        .prd_idx(prd_rd_idx), .prd_data(prd_rd_data),
        .sh_idx(sh_idx), .sh_data(sh_data), .sh_prd(sh_prd)
    );
endmodule

// File: tb/sim_trap_entry_unit.sv
`timescale 1ns/1ps
module sim_trap_entry_unit;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        step, gpr_we, prd_we, prd_wdata, ctl_we, ctl_ie, ctl_sup, ent_we;
    logic        trap_req, trap_rewind;
    logic [3:0]  inst_len;
    logic [2:0]  gpr_idx, rd_idx, sh_idx, ctl_thr, trap_cause, sh_thr, act_thr;
    logic [1:0]  prd_idx, prd_rd_idx;
    logic [15:0] gpr_wdata, ent_addr, fault_addr, rd_data, sh_data, sh_pc, pc;
    logic        prd_rd_data, sh_ie, sh_sup, ie, sup, trap_taken;
    logic [3:0]  sh_prd;

    int n_chk = 0, n_bad = 0;
    logic [15:0] exp_r [8];
    logic [15:0] exp_pc, exp_sh;

    always #5 clk = ~clk;

    trap_entry_unit u0 (
        .clk(clk), .rst_n(rst_n), .step(step), .inst_len(inst_len),
        .gpr_we(gpr_we), .gpr_idx(gpr_idx), .gpr_wdata(gpr_wdata),
        .prd_we(prd_we), .prd_idx(prd_idx), .prd_wdata(prd_wdata),
        .ctl_we(ctl_we), .ctl_ie(ctl_ie), .ctl_sup(ctl_sup), .ctl_thr(ctl_thr),
        .ent_we(ent_we), .ent_addr(ent_addr),
        .trap_req(trap_req), .trap_cause(trap_cause), .trap_rewind(trap_rewind),
        .fault_addr(fault_addr),
        .rd_idx(rd_idx), .rd_data(rd_data), .prd_rd_idx(prd_rd_idx), .prd_rd_data(prd_rd_data),
        .sh_idx(sh_idx), .sh_data(sh_data), .sh_prd(sh_prd),
        .sh_pc(sh_pc), .sh_ie(sh_ie), .sh_sup(sh_sup), .sh_thr(sh_thr),
        .pc(pc), .ie(ie), .sup(sup), .act_thr(act_thr), .trap_taken(trap_taken)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clr();
        step = 0; inst_len = 0; gpr_we = 0; gpr_idx = 0; gpr_wdata = 0;
        prd_we = 0; prd_idx = 0; prd_wdata = 0; ctl_we = 0; ctl_ie = 0;
        ctl_sup = 0; ctl_thr = 0; ent_we = 0; ent_addr = 0; trap_req = 0;
        trap_cause = 0; trap_rewind = 0; fault_addr = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        clr();
    endtask

    task automatic rd(input int i, output logic [15:0] v);
        rd_idx = 3'(i);
        #1 v = rd_data;
    endtask

    task automatic shd(input int i, output logic [15:0] v);
        sh_idx = 3'(i);
        #1 v = sh_data;
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        clr(); rd_idx = 0; sh_idx = 0; prd_rd_idx = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 pc", pc, 0); chk("R1 ie", ie, 0); chk("R1 sup", sup, 1);
        chk("R1 thr", act_thr, 1); chk("R1 taken", trap_taken, 0);
        for (int i = 0; i < 8; i++) begin
            rd(i, v);
            chk("R1 gpr", v, (i == 0) ? 16'h0403 : 16'h0);
        end
        for (int i = 0; i < 4; i++) begin
            prd_rd_idx = 2'(i); #1 chk("R1 prd", prd_rd_data, 0);
        end

        // R2 load registers and predicates while stepping
        exp_pc = 0;
        for (int i = 0; i < 8; i++) begin
            step = 1; inst_len = 4'(i + 1); gpr_we = 1; gpr_idx = 3'(i);
            gpr_wdata = 16'h1000 + 16'(i * 16'h111);
            prd_we = (i < 4); prd_idx = 2'(i); prd_wdata = i[0];
            exp_r[i] = 16'h1000 + 16'(i * 16'h111);
            exp_pc = exp_pc + 16'(i + 1);
            tick();
            chk("R2 pc", pc, exp_pc);
        end
        for (int i = 0; i < 8; i++) begin rd(i, v); chk("R2 gpr", v, exp_r[i]); end
        for (int i = 0; i < 4; i++) begin
            prd_rd_idx = 2'(i); #1 chk("R2 prd", prd_rd_data, i[0]);
        end

        // R3 trap with interrupts disabled
        step = 1; inst_len = 2; trap_req = 1; trap_cause = 5;
        gpr_we = 1; gpr_idx = 0; gpr_wdata = 16'h3333; exp_r[0] = 16'h3333;
        exp_pc = exp_pc + 2;
        tick();
        chk("R3 pc", pc, exp_pc); chk("R3 taken", trap_taken, 0);
        rd(0, v); chk("R3 r0", v, 16'h3333); chk("R3 ie", ie, 0);

        // R2 entry address write
        step = 1; ent_we = 1; ent_addr = 16'h0200;
        tick();

        // R4..R8 sweep over cause and rewind
        for (int k = 0; k < 8; k++) begin
            logic [2:0] c;
            c = (k < 2) ? 3'd1 : (k < 4) ? 3'd2 : (k < 6) ? 3'd4 : 3'd5;
            step = 1; inst_len = 4; gpr_we = 1; gpr_idx = 0;
            gpr_wdata = 16'hA000 + 16'(k); ctl_we = 1; ctl_ie = 1; ctl_sup = 0; ctl_thr = 3;
            exp_r[0] = 16'hA000 + 16'(k); exp_pc = exp_pc + 4;
            tick();
            chk("R2 ctl ie", ie, 1); chk("R2 ctl thr", act_thr, 3);
            step = 1; inst_len = 6; trap_req = 1; trap_cause = c; trap_rewind = k[0];
            fault_addr = 16'hF000 + 16'(k); gpr_we = 1; gpr_idx = 0; gpr_wdata = 16'hBEEF;
            exp_sh = k[0] ? exp_pc : exp_pc + 16'd6;
            tick();
            chk("R5 taken", trap_taken, 1); chk("R5 pc", pc, 16'h0200);
            chk("R5 ie", ie, 0); chk("R5 sup", sup, 1); chk("R5 thr", act_thr, 1);
            chk("R6 shpc", sh_pc, exp_sh);
            chk("R4 shie", sh_ie, 1); chk("R4 shsup", sh_sup, 0); chk("R4 shthr", sh_thr, 3);
            chk("R4 shprd", sh_prd, 4'b1010);
            shd(0, v); chk("R4 sh r0", v, 16'hA000 + 16'(k));
            shd(3, v); chk("R4 sh r3", v, exp_r[3]);
            rd(0, v); chk("R8 r0 cause", v, 16'(c));
            exp_r[0] = 16'(c);
            step = 1; inst_len = 2; gpr_we = 1; gpr_idx = 2; gpr_wdata = 16'h5500 + 16'(k);
            tick();
            chk("R5 pulse end", trap_taken, 0);
            if (c <= 3'd2) begin
                exp_r[1] = 16'hF000 + 16'(k);
                exp_pc = 16'h0200;
            end else begin
                exp_r[2] = 16'h5500 + 16'(k);
                exp_pc = 16'h0202;
            end
            chk("R7 pc", pc, exp_pc);
            rd(1, v); chk("R7 r1", v, exp_r[1]);
            rd(2, v); chk("R7 r2", v, exp_r[2]);
        end

        // R2 PC wrap at the word width
        step = 1; ent_we = 1; ent_addr = 16'hFFFE; ctl_we = 1; ctl_ie = 1; ctl_sup = 1; ctl_thr = 2;
        exp_pc = exp_pc;
        tick();
        trap_req = 1; trap_cause = 5;
        tick();
        chk("R6 shpc nostep", sh_pc, exp_pc); chk("R5 wrap entry", pc, 16'hFFFE);
        step = 1; inst_len = 4;
        tick();
        chk("R2 wrap", pc, 16'h0002);

        // R9 halt on zero thread count
        step = 1; inst_len = 2; ctl_we = 1; ctl_ie = 1; ctl_sup = 0; ctl_thr = 0;
        tick();
        chk("R9 thr0", act_thr, 0); chk("R9 pc4", pc, 16'h0004);
        step = 1; inst_len = 4; trap_req = 1; trap_cause = 1; gpr_we = 1; gpr_idx = 5;
        gpr_wdata = 16'h1234; ctl_we = 1; ctl_thr = 2; ctl_ie = 0;
        tick();
        chk("R9 pc", pc, 16'h0004); chk("R9 thr", act_thr, 0); chk("R9 ie", ie, 1);
        chk("R9 taken", trap_taken, 0);
        rd(5, v); chk("R9 r5", v, exp_r[5]);
        tick();
        chk("R9 taken2", trap_taken, 0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule